// File: doc/BRIEF.md
# Multi-Channel Request-Driven Iteration Counter

This block is a bank of channels that each count pulses on one chosen input line by stepping a reloadable iteration counter down by one per accepted request, in the way a transfer channel retires one minor loop per service request. Input lines are synchronized, routed to a flat vector of request sources, and every channel picks one source through its own selector. A rising or falling edge of the picked source, chosen per channel, produces a single-cycle request. No data moves anywhere.

Software programs a begin value and a current value for each channel through a small write port. It arms the channel with a set-request command and afterwards derives the pulse count as begin value minus current value. The bank also gives that difference directly on a per-channel count output. When a channel's counter runs out, the channel reloads the begin value, raises a sticky done flag, and raises an interrupt line if that is enabled.

Top module: `iter_count_bank`

## Requirements
- R1: After reset every channel holds BITER = CITER = 0x7FFF, count 0, done 0, interrupt 0, request enable 0, routing disabled, and source selector = 49 + channel number.
- R2: A channel accepts a request only when its routing enable (CFG bit 6) and its request enable are both set and its selected source shows a qualifying edge. Source numbers 49 to 53 carry input lines 0 to 4, and every other source number never requests.
- R3: Each accepted request lowers CITER by one. CFG bit 7 picks the qualifying edge (0 = rising, 1 = falling). The count output equals (BITER − CITER) mod 2^15 one cycle after the registers change.
- R4: A request that arrives while CITER is 1 or 0 loads CITER from BITER and sets the channel's done flag, and later requests go on decrementing from the reloaded value.
- R5: The done flag (STAT bit 0) stays set until software writes STAT with bit 0 = 1. The interrupt output of a channel equals its done flag AND its interrupt enable (CFG bit 8).
- R6: A software write to CITER in the same cycle as an accepted request loads the written value, and that request is dropped.
- R7: Writing register 4 sets the request enable of the channel whose number is in the data bits, and writing register 5 clears it. The enable reads back as STAT bit 1.
- R8: Register address = channel × 8 + register (0 CFG with source selector in bits 5:0, 1 BITER, 2 CITER, 3 STAT). The read data is registered and appears one clock after the read address.
- R9: Channels count independently and at the same time, and two channels that select the same source both count its edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | NUM_PORTS (5) | Asynchronous pulse input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (6) | Write address, channel × 8 + register |
| wr_data | input | DW (16) | Write data |
| rd_addr | input | AW (6) | Read address |
| rd_data | output | DW (16) | Registered read data |
| count_o | output | NUM_CH×CNT_W (75) | Per-channel BITER − CITER, channel 0 in the low bits |
| irq_o | output | NUM_CH (5) | Per-channel major-done interrupt |

## Verification
The bench builds the bank with its default parameters: five channels, five input lines, a 15-bit counter, and a 64-entry source space whose lines start at 49. These match the register encodings that software relies on. Small BITER values of 3 and 7 let exhaustion and reload happen within a few pulses rather than after 32767. A CITER write is timed onto the exact cycle of a request to reach the write-over-decrement priority. A random phase toggles the lines with two channels sharing one line and one channel counting on falling edges, so simultaneous independent counting and reloads occur many times.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int SRC_W   = 6;
  localparam int NUM_SRC = 1 << SRC_W;
  localparam int REG_W   = 3;

  typedef enum logic [REG_W-1:0] {
    REG_CFG   = 3'd0,
    REG_BITER = 3'd1,
    REG_CITER = 3'd2,
    REG_STAT  = 3'd3,
    REG_SETRQ = 3'd4,
    REG_CLRRQ = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic             irq_en;
    logic             fall;
    logic             route_en;
    logic [SRC_W-1:0] src;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i]   <= 1'b0;
        sync_out[i] <= 1'b0;
      end else begin
        stage1[i]   <= async_in[i];
        sync_out[i] <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/pcnt_channel.sv
module pcnt_channel
  import pcnt_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int DW      = 16,
  parameter int RST_SRC = 49
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_vec,
  input  logic               wr_cfg,
  input  logic               wr_biter,
  input  logic               wr_citer,
  input  logic               wr_stat,
  input  logic               set_erq,
  input  logic               clr_erq,
  input  logic [DW-1:0]      wdata,
  output ch_cfg_t            cfg_o,
  output logic [CNT_W-1:0]   biter_o,
  output logic [CNT_W-1:0]   citer_o,
  output logic               done_o,
  output logic               erq_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               irq_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic sel_lvl, prev_lvl, edge_hit, req, wrap;

  assign sel_lvl  = src_vec[cfg_o.src];
  assign edge_hit = cfg_o.fall ? (prev_lvl & ~sel_lvl) : (~prev_lvl & sel_lvl);
  assign req      = cfg_o.route_en & erq_o & edge_hit;
  assign wrap     = (citer_o <= CNT_W'(1));
  assign irq_o    = done_o & cfg_o.irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl  <= 1'b0;
      cfg_o     <= '{irq_en: 1'b0, fall: 1'b0, route_en: 1'b0, src: SRC_W'(RST_SRC)};
      biter_o   <= ALL_ONES;
      citer_o   <= ALL_ONES;
      done_o    <= 1'b0;
      erq_o     <= 1'b0;
      count_o   <= '0;
    end else begin
      prev_lvl <= sel_lvl;
      count_o  <= biter_o - citer_o;
      if (wr_cfg)   cfg_o   <= ch_cfg_t'(wdata[CFG_W-1:0]);
      if (wr_biter) biter_o <= wdata[CNT_W-1:0];
      if (wr_citer)      citer_o <= wdata[CNT_W-1:0];
      else if (req)      citer_o <= wrap ? biter_o : citer_o - CNT_W'(1);
      if (req && !wr_citer && wrap) done_o <= 1'b1;
      else if (wr_stat && wdata[0]) done_o <= 1'b0;
      if (set_erq)      erq_o <= 1'b1;
      else if (clr_erq) erq_o <= 1'b0;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!req && !wr_citer) |=> $stable(citer_o)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (req && !wr_citer && citer_o > CNT_W'(1)) |=> (citer_o == $past(citer_o) - CNT_W'(1))); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (req && !wr_citer && citer_o <= CNT_W'(1)) |=> (citer_o == $past(biter_o) && done_o)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_o && !wr_stat) |=> done_o); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_citer |=> (citer_o == $past(wdata[CNT_W-1:0]))); // R6
endmodule

// File: rtl/iter_count_bank.sv
module iter_count_bank
  import pcnt_pkg::*;
#(
  parameter int NUM_CH        = 5,
  parameter int NUM_PORTS     = 5,
  parameter int CNT_W         = 15,
  parameter int DW            = 16,
  parameter int PORT_SRC_BASE = 49,
  localparam int CH_AW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW           = CH_AW + REG_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PORTS-1:0]    port_in,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [NUM_CH*CNT_W-1:0] count_o,
  output logic [NUM_CH-1:0]       irq_o
);
  logic [NUM_PORTS-1:0] port_sync;
  logic [NUM_SRC-1:0]   src_vec;
  logic [CH_AW-1:0]     wr_ch, rd_ch, cmd_ch;
  reg_sel_e             wr_reg, rd_reg;

  ch_cfg_t          cfg_a   [NUM_CH];
  logic [CNT_W-1:0] biter_a [NUM_CH];
  logic [CNT_W-1:0] citer_a [NUM_CH];
  logic [NUM_CH-1:0] done_a, erq_a;

  pcnt_sync #(.WIDTH(NUM_PORTS)) u_sync (
    .clk(clk), .rst(rst), .async_in(port_in), .sync_out(port_sync)
  );

  always_comb begin
    src_vec = '0;
    for (int i = 0; i < NUM_PORTS; i++) src_vec[PORT_SRC_BASE + i] = port_sync[i];
  end

  assign wr_ch  = wr_addr[AW-1:REG_W];
  assign wr_reg = reg_sel_e'(wr_addr[REG_W-1:0]);
  assign rd_ch  = rd_addr[AW-1:REG_W];
  assign rd_reg = reg_sel_e'(rd_addr[REG_W-1:0]);
  assign cmd_ch = wr_data[CH_AW-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CH_AW'(g));

    pcnt_channel #(.CNT_W(CNT_W), .DW(DW), .RST_SRC(PORT_SRC_BASE + g)) u_ch (
      .clk(clk), .rst(rst), .src_vec(src_vec),
      .wr_cfg  (hit && wr_reg == REG_CFG),
      .wr_biter(hit && wr_reg == REG_BITER),
      .wr_citer(hit && wr_reg == REG_CITER),
      .wr_stat (hit && wr_reg == REG_STAT),
      .set_erq (wr_en && wr_reg == REG_SETRQ && cmd_ch == CH_AW'(g)),
      .clr_erq (wr_en && wr_reg == REG_CLRRQ && cmd_ch == CH_AW'(g)),
      .wdata(wr_data),
      .cfg_o(cfg_a[g]), .biter_o(biter_a[g]), .citer_o(citer_a[g]),
      .done_o(done_a[g]), .erq_o(erq_a[g]),
      .count_o(count_o[g*CNT_W +: CNT_W]), .irq_o(irq_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (int'(rd_ch) < NUM_CH) begin
        case (rd_reg)
          REG_CFG:   rd_data <= DW'(cfg_a[rd_ch]);
          REG_BITER: rd_data <= DW'(biter_a[rd_ch]);
          REG_CITER: rd_data <= DW'(citer_a[rd_ch]);
          REG_STAT:  rd_data <= DW'({erq_a[rd_ch], done_a[rd_ch]});
          default:   rd_data <= '0;
        endcase
      end
    end
  end

  AST_SETRQ_ARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_reg == REG_SETRQ && int'(cmd_ch) < NUM_CH) |=> erq_a[$past(cmd_ch)]); // R7
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    ((irq_o & ~done_a) == '0)); // R5
endmodule

// File: tb/iter_count_bank_test.sv
module iter_count_bank_test;
  localparam int NCH = 5;
  localparam int CW  = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] port_in = '0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [NCH*CW-1:0] count_o;
  logic [NCH-1:0] irq_o;

  int n_checks = 0, n_fail = 0;

  int m_port[NCH], m_fall[NCH], m_ie[NCH], m_biter[NCH], m_citer[NCH], m_done[NCH];

  iter_count_bank uut (
    .clk(clk), .rst(rst), .port_in(port_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count_o(count_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input int got, input int exp, input string tag);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int ch, input int rg, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(ch * 8 + rg); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int rg, output int val);
    @(negedge clk);
    rd_addr = 6'(ch * 8 + rg);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  function automatic int cnt(input int ch);
    return int'(count_o[ch*CW +: CW]);
  endfunction

  function automatic int exp_cnt(input int ch);
    return (m_biter[ch] - m_citer[ch]) & 32'h7FFF;
  endfunction

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic toggle(input logic [4:0] mask);
    @(negedge clk);
    port_in = port_in ^ mask;
    settle();
  endtask

  task automatic model_step(input logic [4:0] mask);
    for (int c = 0; c < NCH; c++) begin
      if (mask[m_port[c]] && (port_in[m_port[c]] == (m_fall[c] == 0))) begin
        if (m_citer[c] <= 1) begin m_citer[c] = m_biter[c]; m_done[c] = 1; end
        else m_citer[c] = m_citer[c] - 1;
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NCH; c++) chk(cnt(c), 0, "R1 count");
    chk(int'(irq_o), 0, "R1 irq");
    rd(2, 0, v); chk(v, 51, "R1 cfg source ch2");
    rd(0, 2, v); chk(v, 32'h7FFF, "R1 citer");
    rd(4, 1, v); chk(v, 32'h7FFF, "R1 biter");
    rd(0, 3, v); chk(v, 0, "R1 R8 status");

    // R2 routing enabled but request not armed
    wr(0, 0, 49 | (1 << 6));
    toggle(5'b00001); toggle(5'b00001);
    chk(cnt(0), 0, "R2 unarmed");

    // R7 arm channel 0, R3 rising edge counts
    wr(0, 4, 0);
    rd(0, 3, v); chk(v, 2, "R7 erq readback");
    toggle(5'b00001); chk(cnt(0), 1, "R3 rising");
    toggle(5'b00001); chk(cnt(0), 1, "R3 falling ignored");

    // R2 non-port source never requests
    wr(1, 0, 10 | (1 << 6)); wr(1, 4, 1);
    toggle(5'b11111); toggle(5'b11111);
    chk(cnt(1), 0, "R2 dead source");
    chk(cnt(0), 2, "R9 ch0 alongside");

    // R3 falling polarity on channel 2
    wr(2, 0, 51 | (1 << 6) | (1 << 7)); wr(2, 4, 2);
    toggle(5'b00100); chk(cnt(2), 0, "R3 rising ignored in fall mode");
    toggle(5'b00100); chk(cnt(2), 1, "R3 falling counted");

    // R4 / R5 exhaustion, reload, sticky done, interrupt
    wr(3, 0, 52 | (1 << 6) | (1 << 8)); wr(3, 1, 3); wr(3, 2, 3); wr(3, 4, 3);
    for (int k = 0; k < 2; k++) begin toggle(5'b01000); toggle(5'b01000); end
    chk(cnt(3), 2, "R3 partial count");
    chk(int'(irq_o[3]), 0, "R5 no irq yet");
    toggle(5'b01000); toggle(5'b01000);
    chk(cnt(3), 0, "R4 reload count");
    rd(3, 2, v); chk(v, 3, "R4 citer reloaded");
    rd(3, 3, v); chk(v & 1, 1, "R4 done set");
    chk(int'(irq_o[3]), 1, "R5 irq raised");
    toggle(5'b01000); toggle(5'b01000);
    chk(cnt(3), 1, "R4 continues after reload");
    wr(3, 3, 0);
    chk(int'(irq_o[3]), 1, "R5 sticky on zero write");
    wr(3, 3, 1);
    chk(int'(irq_o[3]), 0, "R5 cleared");

    // R6 CITER write in the same cycle as a request (port 0 is low here)
    @(negedge clk); port_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(0 * 8 + 2); wr_data = 16'd100;
    @(negedge clk); wr_en = 1'b0;
    settle();
    rd(0, 2, v); chk(v, 100, "R6 write wins");
    toggle(5'b00001);

    // R7 clear request stops counting
    wr(0, 5, 0);
    toggle(5'b00001); toggle(5'b00001);
    rd(0, 2, v); chk(v, 100, "R7 cleared request");

    // R9 random phase, fresh reset
    @(negedge clk); port_in = '0; rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    m_port = '{0, 0, 2, 3, 4};
    m_fall = '{0, 0, 1, 0, 0};
    m_ie   = '{0, 0, 0, 1, 1};
    m_biter = '{32'h7FFF, 50, 32'h7FFF, 3, 7};
    for (int c = 0; c < NCH; c++) begin
      m_citer[c] = m_biter[c]; m_done[c] = 0;
      wr(c, 0, (49 + m_port[c]) | (1 << 6) | (m_fall[c] << 7) | (m_ie[c] << 8));
      wr(c, 1, m_biter[c]); wr(c, 2, m_biter[c]); wr(c, 4, c);
    end
    for (int it = 0; it < 300; it++) begin
      logic [4:0] mask;
      mask = 5'($urandom_range(1, 31));
      toggle(mask);
      model_step(mask);
      if (it % 25 == 24)
        for (int c = 0; c < NCH; c++) chk(cnt(c), exp_cnt(c), "R9 random count");
    end
    for (int c = 0; c < NCH; c++) begin
      chk(cnt(c), exp_cnt(c), "R9 final count");
      rd(c, 3, v); chk(v & 1, m_done[c], "R4 R9 final done");
      chk(int'(irq_o[c]), m_done[c] & m_ie[c], "R5 final irq");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule